// File: doc/BRIEF.md
# E1 Idle Frame Transmitter

This block produces an endless stream of E1 idle frames as a single serial bit. It runs in the transmit bit-clock domain. A clock enable marks each bit period, and the block moves one bit forward on every cycle where that enable is high. Each frame holds 32 octets, which is 256 bits. Octet 0 (timeslot 0) carries a framing word taken from a fixed table of 16 words. The frame counter selects the table entry, so the framing words and non-framing words alternate with the spare and CRC bit positions set as the idle pattern requires. Every other timeslot carries all ones.

A line interface can use the block to keep a far end in frame alignment while no payload is available. It can also serve as a known-good framed source during bring-up. Transmission begins as soon as reset is released and needs no start command. A frame-start marker identifies the first bit of every frame so that downstream logic can lock onto the frame boundary.

Top module: `e1_idle_tx`

## Requirements
- R1: While reset is held and right after it is released, the block sits at bit 0 of frame-table entry 0: frame_start is 1 and tx_bit is 0, the most significant bit of 0x1B. Output then starts without any further command, and the first octet sent is 0x1B.
- R2: A frame is 256 transmitted bits long. frame_start is 1 exactly during the first bit of each frame (the first bit of timeslot 0) and 0 during the other 255 bits.
- R3: Each octet is sent with its most significant bit first. Bit 7 is sent in the first bit time of the octet and bit 0 in the eighth.
- R4: Timeslot 0 of frame n carries entry n mod 16 of this table: 1B, 40, 1B, 40, 1B, C0, 1B, 40, 1B, C0, 9B, C0, 9B, 40, 9B, 40 (hex).
- R5: Timeslots 1 to 31 of every frame are sent as 0xFF, so tx_bit is 1 throughout them.
- R6: The position advances by one bit only on clock cycles where bit_en is 1. On cycles where bit_en is 0, tx_bit and frame_start keep their values, and the bit sequence resumes later with no bit lost or repeated.
- R7: After table entry 15 has been sent, the next frame uses entry 0 again, and the cycle repeats with no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit clock enable; one bit period passes per high cycle |
| tx_bit | output | 1 | Serial line data for the current bit period |
| frame_start | output | 1 | High during the first bit of each frame |

## Verification
A wrong bit counter shows up within one frame: frame_start falls on the wrong bit, or fewer or more than 256 bits pass between markers. A wrong frame counter appears in the next timeslot 0, where the framing word differs from the table entry. A table slip shows only at the 16-frame wrap, so the stimulus runs through more than 16 frames. A counter that moves while the enable is low breaks the frame content of a gapped frame within a few bits.

// File: rtl/e1_tx_pkg.sv
package e1_tx_pkg;

    localparam int OCTET_W        = 8;
    localparam int DEF_FRAME_OCTS = 32;
    localparam int DEF_SEQ_LEN    = 16;
    localparam logic [OCTET_W-1:0] IDLE_FILL = 8'hFF;

    // Timeslot-0 idle word for a given frame number within the multiframe.
    function automatic logic [OCTET_W-1:0] ts0_word(input logic [3:0] idx);
        logic [OCTET_W-1:0] w;
        case (idx)
            4'd0, 4'd2, 4'd4, 4'd6, 4'd8: w = 8'h1B;
            4'd10, 4'd12, 4'd14:          w = 8'h9B;
            4'd5, 4'd9, 4'd11:            w = 8'hC0;
            default:                      w = 8'h40;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/e1_tx_position.sv
module e1_tx_position #(
    parameter int FRAME_OCTS = e1_tx_pkg::DEF_FRAME_OCTS,
    parameter int SEQ_LEN    = e1_tx_pkg::DEF_SEQ_LEN,
    localparam int FRAME_BITS = FRAME_OCTS * e1_tx_pkg::OCTET_W,
    localparam int BW         = $clog2(FRAME_BITS),
    localparam int SW         = $clog2(SEQ_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] seq_idx
);

    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [SW-1:0] LAST_SEQ = SW'(SEQ_LEN - 1);

    typedef struct packed {
        logic [BW-1:0] bitpos;
        logic [SW-1:0] frame;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (bit_en) begin
            if (pos_q.bitpos == LAST_BIT) begin
                pos_d.bitpos = '0;
                pos_d.frame  = (pos_q.frame == LAST_SEQ) ? '0 : pos_q.frame + 1'b1;
            end else begin
                pos_d.bitpos = pos_q.bitpos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_idx = pos_q.bitpos;
    assign seq_idx = pos_q.frame;

    // R6: no movement without an enable
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(bit_idx) && $stable(seq_idx));

    // R6: one step per enabled cycle inside a frame
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx != LAST_BIT) |=> bit_idx == $past(bit_idx) + 1'b1);

    // R2/R7: frame end wraps the bit position and moves the table index
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == LAST_BIT) |=>
            bit_idx == '0 &&
            seq_idx == (($past(seq_idx) == LAST_SEQ) ? '0 : $past(seq_idx) + 1'b1));

    // R4: the table index is fixed for the whole frame
    p_seq_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx != LAST_BIT) |=> $stable(seq_idx));

endmodule

// File: rtl/e1_tx_octet_src.sv
module e1_tx_octet_src #(
    parameter int FRAME_OCTS = e1_tx_pkg::DEF_FRAME_OCTS,
    parameter int SEQ_LEN    = e1_tx_pkg::DEF_SEQ_LEN,
    localparam int OW        = $clog2(FRAME_OCTS),
    localparam int SW        = $clog2(SEQ_LEN)
) (
    input  logic [OW-1:0]                     octet_idx,
    input  logic [SW-1:0]                     seq_idx,
    output logic [e1_tx_pkg::OCTET_W-1:0]     octet
);

    logic [3:0] tbl_idx;

    always_comb begin
        tbl_idx = 4'(seq_idx);
        if (octet_idx == '0) octet = e1_tx_pkg::ts0_word(tbl_idx);
        else                 octet = e1_tx_pkg::IDLE_FILL;
    end

endmodule

// File: rtl/e1_idle_tx.sv
module e1_idle_tx #(
    parameter int FRAME_OCTS = e1_tx_pkg::DEF_FRAME_OCTS,
    parameter int SEQ_LEN    = e1_tx_pkg::DEF_SEQ_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic tx_bit,
    output logic frame_start
);

    localparam int OCT_W      = e1_tx_pkg::OCTET_W;
    localparam int FRAME_BITS = FRAME_OCTS * OCT_W;
    localparam int BW         = $clog2(FRAME_BITS);
    localparam int SW         = $clog2(SEQ_LEN);
    localparam int IW         = $clog2(OCT_W);
    localparam int OW         = BW - IW;

    logic [BW-1:0]    bit_idx;
    logic [SW-1:0]    seq_idx;
    logic [OW-1:0]    octet_idx;
    logic [IW-1:0]    bit_in_oct;
    logic [OCT_W-1:0] octet;

    e1_tx_position #(.FRAME_OCTS(FRAME_OCTS), .SEQ_LEN(SEQ_LEN)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_idx (bit_idx),
        .seq_idx (seq_idx)
    );

    assign octet_idx  = bit_idx[BW-1:IW];
    assign bit_in_oct = bit_idx[IW-1:0];

    e1_tx_octet_src #(.FRAME_OCTS(FRAME_OCTS), .SEQ_LEN(SEQ_LEN)) u_src (
        .octet_idx (octet_idx),
        .seq_idx   (seq_idx),
        .octet     (octet)
    );

    // MSB first: bit time 0 of an octet carries bit 7.
    always_comb begin
        tx_bit      = octet[IW'(OCT_W - 1) - bit_in_oct];
        frame_start = (bit_idx == '0);
    end

    // R5: payload timeslots only ever carry ones
    p_payload_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (octet_idx != '0) |-> tx_bit);

    // R2: the marker lasts exactly one enabled bit time
    p_marker_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && bit_en) |=> !frame_start);

    // R2: the marker comes back after the last bit of a frame
    p_marker_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_idx == BW'(FRAME_BITS - 1)) |=> frame_start);

endmodule

// File: tb/sim_e1_idle_tx.sv
module sim_e1_idle_tx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic tx_bit, frame_start;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // Expected timeslot-0 words by frame number mod 16 (R4)
    localparam logic [7:0] EXP_TS0 [16] = '{
        8'h1B, 8'h40, 8'h1B, 8'h40, 8'h1B, 8'hC0, 8'h1B, 8'h40,
        8'h1B, 8'hC0, 8'h9B, 8'hC0, 8'h9B, 8'h40, 8'h9B, 8'h40 };

    e1_idle_tx u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .tx_bit      (tx_bit),
        .frame_start (frame_start)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic en);
        bit_en = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Sends one frame with bit_en gaps picked by gap_mode and checks its content.
    task automatic run_frame(input int fnum, input int gap_mode);
        logic [7:0] ts0 = '0;
        int ones_bad = 0;
        int fs_cnt = 0;
        int fs_bad = 0;
        int hold_bad = 0;
        for (int b = 0; b < 256; b++) begin
            if (b < 8) ts0 = {ts0[6:0], tx_bit};
            else if (!tx_bit) ones_bad++;
            if (frame_start) begin
                fs_cnt++;
                if (b != 0) fs_bad++;
            end
            if (gap_mode != 0 && (b % gap_mode) == 1) begin
                logic t0, f0;
                t0 = tx_bit;
                f0 = frame_start;
                step(1'b0);
                step(1'b0);
                if (tx_bit != t0 || frame_start != f0) hold_bad++;
            end
            step(1'b1);
        end
        check(ts0 == EXP_TS0[fnum % 16], "R4", $sformatf("frame %0d ts0", fnum),
              ts0, EXP_TS0[fnum % 16]);
        check(ones_bad == 0, "R5", $sformatf("frame %0d zero bits in payload", fnum),
              ones_bad, 0);
        check(fs_cnt == 1 && fs_bad == 0, "R2", $sformatf("frame %0d marker count", fnum),
              fs_cnt, 1);
        if (gap_mode != 0)
            check(hold_bad == 0, "R6", $sformatf("frame %0d outputs moved while idle", fnum),
                  hold_bad, 0);
    endtask

    initial begin
        // R1: state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(frame_start == 1'b1, "R1", "frame_start in reset", frame_start, 1);
        check(tx_bit == 1'b0, "R1", "tx_bit in reset", tx_bit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(frame_start == 1'b1 && tx_bit == 1'b0, "R1", "first bit after reset",
              {frame_start, tx_bit}, 2);

        // R3/R4/R5/R2/R7: 18 frames so the table wraps (frames 16, 17 reuse entries 0, 1)
        for (int f = 0; f < 18; f++) begin
            run_frame(f, 0);
        end
        // R7: frame 18 must again carry entry 2 after the wrap
        run_frame(18, 0);

        // R6: gapped frames keep content intact
        run_frame(19, 3);
        run_frame(20, 7);

        // R3: first four bits of frame 21 (entry 5 = C0) are 1,1,0,0
        begin
            logic [3:0] nib = '0;
            for (int b = 0; b < 4; b++) begin
                nib = {nib[2:0], tx_bit};
                step(1'b1);
            end
            check(nib == 4'hC, "R3", "msb-first nibble of C0", nib, 4'hC);
        end

        // R1: reset in mid-frame returns to entry 0, bit 0
        repeat (37) step(1'b1);
        rst_n = 1'b0;
        step(1'b1);
        check(frame_start == 1'b1 && tx_bit == 1'b0, "R1", "mid-frame reset",
              {frame_start, tx_bit}, 2);
        rst_n = 1'b1;
        bit_en = 1'b0;
        @(negedge clk);
        run_frame(0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule